// File: doc/BRIEF.md
# SHA-256 Iterative Compression Core

This core computes a SHA-256 digest over a stream of 512-bit blocks that have already been padded. A block is handed over in one cycle as a 512-bit word together with a flag marking the final block of the message. The core then runs one compression round per clock. The sixteen message words sit in a sliding window, and the remaining 48 schedule words are derived inside that window as the rounds advance. After the 64th round, one extra cycle folds the working variables into the 256-bit chaining value.

A message of several blocks is hashed by presenting its blocks one after another. The chaining value carries over from block to block until a start pulse loads the standard initial values again. When the final block has been folded in, the core raises a one-cycle done pulse, and the chaining value then on the output is the message digest.

The controller has three named states. `ST_IDLE` waits for a block. `ST_ROUND` performs rounds 0 to 63. `ST_FOLD` adds the working variables into the chaining value. The transitions are:

- IDLE to ROUND when a block is accepted.
- ROUND to ROUND while the round index is below 63.
- ROUND to FOLD after round 63.
- FOLD to IDLE unconditionally.

Top module: `sha256_iter_core`

## Requirements
- R1: While reset is asserted and right after it is released, `ready_o` is 1, `done_o` is 0 and `digest_o` holds the standard initial value 6a09e667 bb67ae85 3c6ef372 a54ff53a 510e527f 9b05688c 1f83d9ab 5be0cd19. H1 sits in bits [255:224] and H8 in bits [31:0].
- R2: A `start_i` pulse while `ready_o` is 1 reloads the chaining value with the initial value. It shows on `digest_o` the following cycle.
- R3: A block is accepted in a cycle where `ready_o` and `blk_valid_i` are both 1, and `ready_o` is 0 in the following cycle. Schedule word W0 is `blk_data_i[511:480]` and W15 is `blk_data_i[31:0]`.
- R4: After acceptance, `ready_o` stays 0 for exactly 65 cycles: 64 round cycles and one fold cycle.
- R5: For a final block, `digest_o` equals the SHA-256 digest of the message once `done_o` is 1. The one-block padded "abc" message gives ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad.
- R6: A block presented without the last flag updates the chaining value but raises no done pulse. The next block continues from that chaining value.
- R7: `done_o` is 1 for exactly one cycle, the first cycle in which `ready_o` is 1 again after a final block.
- R8: `start_i` is ignored while `ready_o` is 0.
- R9: `blk_valid_i` is ignored while `ready_o` is 0, and no block is accepted from it.
- R10: When `start_i` and `blk_valid_i` are both 1 in an accepting cycle, the block is hashed from the initial value rather than from the previous chaining value.
- R11: `digest_o` does not change during the cycles between acceptance and the fold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Reload the chaining value with the initial value |
| blk_valid_i | input | 1 | A padded block is present on `blk_data_i` |
| blk_last_i | input | 1 | The presented block is the last of the message |
| blk_data_i | input | 512 | Padded block, W0 in the top 32 bits |
| ready_o | output | 1 | Core is idle and will accept a block |
| done_o | output | 1 | One-cycle pulse: digest of the finished message is valid |
| digest_o | output | 256 | Chaining value / digest, H1 in the top 32 bits |

## Verification
The bench builds the core with its default parameters: a 16-word schedule window and 64 rounds, which is the only configuration that yields true SHA-256. It runs three reference messages:

- The empty message, whose single block holds only padding.
- "abc".
- A 56-byte message that spills into a second block and so exercises chaining.

These messages reach every round constant and every schedule word, plus both the chained and the fresh-start paths. Directed runs then stress the corner cases:

- Start and valid arriving together.
- Start and valid held high in the middle of a busy block.
- A reset applied partway through the rounds.

// File: rtl/sha256_pkg.sv
package sha256_pkg;

    localparam int WORD_W     = 32;
    localparam int MSG_WORDS  = 16;
    localparam int NUM_ROUNDS = 64;
    localparam int STATE_WDS  = 8;
    localparam int BLK_W      = WORD_W * MSG_WORDS;
    localparam int DIG_W      = WORD_W * STATE_WDS;
    localparam int RND_W      = $clog2(NUM_ROUNDS);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } work_t;

    localparam work_t H_INIT = {
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
    };

    localparam word_t K_TAB [NUM_ROUNDS] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t small_sig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t small_sig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t choose(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t majority(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic work_t fold_state(input work_t acc, input work_t wrk);
        work_t r;
        r.a = acc.a + wrk.a;
        r.b = acc.b + wrk.b;
        r.c = acc.c + wrk.c;
        r.d = acc.d + wrk.d;
        r.e = acc.e + wrk.e;
        r.f = acc.f + wrk.f;
        r.g = acc.g + wrk.g;
        r.h = acc.h + wrk.h;
        return r;
    endfunction

endpackage

// File: rtl/sha256_kconst.sv
module sha256_kconst
    import sha256_pkg::*;
(
    input  logic [RND_W-1:0] rnd_i,
    output word_t            k_o
);
    assign k_o = K_TAB[rnd_i];
endmodule

// File: rtl/sha256_sched.sv
module sha256_sched
    import sha256_pkg::*;
#(
    parameter int DEPTH = MSG_WORDS
) (
    input  logic             clk,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [BLK_W-1:0] blk_i,
    output word_t            w_o
);
    localparam int TAP_S1 = DEPTH - 2;
    localparam int TAP_W7 = DEPTH - 7;

    word_t win_q [DEPTH];
    word_t nxt_w;

    assign nxt_w = small_sig1(win_q[TAP_S1]) + win_q[TAP_W7]
                 + small_sig0(win_q[1]) + win_q[0];
    assign w_o   = win_q[0];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        word_t shift_in;
        if (gi == DEPTH - 1) begin : g_tail
            assign shift_in = nxt_w;
        end else begin : g_body
            assign shift_in = win_q[gi+1];
        end

        always_ff @(posedge clk) begin
            if (load_i) begin
                win_q[gi] <= blk_i[BLK_W-1-WORD_W*gi -: WORD_W];
            end else if (shift_i) begin
                win_q[gi] <= shift_in;
            end
        end
    end
endmodule

// File: rtl/sha256_round.sv
module sha256_round
    import sha256_pkg::*;
(
    input  work_t cur_i,
    input  word_t k_i,
    input  word_t w_i,
    output work_t nxt_o
);
    word_t t1;
    word_t t2;

    always_comb begin
        t1 = cur_i.h + big_sig1(cur_i.e) + choose(cur_i.e, cur_i.f, cur_i.g) + k_i + w_i;
        t2 = big_sig0(cur_i.a) + majority(cur_i.a, cur_i.b, cur_i.c);
        nxt_o.h = cur_i.g;
        nxt_o.g = cur_i.f;
        nxt_o.f = cur_i.e;
        nxt_o.e = cur_i.d + t1;
        nxt_o.d = cur_i.c;
        nxt_o.c = cur_i.b;
        nxt_o.b = cur_i.a;
        nxt_o.a = t1 + t2;
    end
endmodule

// File: rtl/sha256_iter_core.sv
module sha256_iter_core
    import sha256_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             blk_valid_i,
    input  logic             blk_last_i,
    input  logic [BLK_W-1:0] blk_data_i,
    output logic             ready_o,
    output logic             done_o,
    output logic [DIG_W-1:0] digest_o
);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROUND,
        ST_FOLD
    } core_state_e;

    core_state_e      state_q;
    core_state_e      state_d;
    logic [RND_W-1:0] rnd_q;
    work_t            work_q;
    work_t            hash_q;
    work_t            round_nxt;
    logic             last_q;
    logic             done_q;
    logic             accept;
    word_t            k_cur;
    word_t            w_cur;

    assign accept = (state_q == ST_IDLE) && blk_valid_i;

    sha256_kconst u_kconst (
        .rnd_i (rnd_q),
        .k_o   (k_cur)
    );

    sha256_sched #(.DEPTH(MSG_WORDS)) u_sched (
        .clk     (clk),
        .load_i  (accept),
        .shift_i (state_q == ST_ROUND),
        .blk_i   (blk_data_i),
        .w_o     (w_cur)
    );

    sha256_round u_round (
        .cur_i (work_q),
        .k_i   (k_cur),
        .w_i   (w_cur),
        .nxt_o (round_nxt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (blk_valid_i)        state_d = ST_ROUND;
            ST_ROUND: if (rnd_q == LAST_RND)  state_d = ST_FOLD;
            ST_FOLD:                          state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hash_q <= H_INIT;
            work_q <= '0;
            rnd_q  <= '0;
            last_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        hash_q <= H_INIT;
                    end
                    if (blk_valid_i) begin
                        work_q <= start_i ? H_INIT : hash_q;
                        last_q <= blk_last_i;
                        rnd_q  <= '0;
                    end
                end
                ST_ROUND: begin
                    work_q <= round_nxt;
                    rnd_q  <= rnd_q + 1'b1;
                end
                ST_FOLD: begin
                    hash_q <= fold_state(hash_q, work_q);
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FOLD) && last_q;
        end
    end

    assign done_o   = done_q;
    assign ready_o  = (state_q == ST_IDLE);
    assign digest_o = hash_q;
endmodule

// File: rtl/sha256_core_chk.sv
module sha256_core_chk
    import sha256_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             blk_valid_i,
    input logic             ready_o,
    input logic             done_o,
    input logic [DIG_W-1:0] digest_o
);
    localparam int BUSY_CYC = NUM_ROUNDS + 1;

    logic [7:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (ready_o) begin
            busy_cnt <= '0;
        end else if (busy_cnt != 8'hff) begin
            busy_cnt <= busy_cnt + 8'd1;
        end
    end

    AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i && !blk_valid_i) |=> (digest_o == DIG_W'(H_INIT))); // R2

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && blk_valid_i) |=> !ready_o); // R3

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (busy_cnt == 8'(BUSY_CYC))); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ready_o && $past(!ready_o))); // R7

    AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && $past(!ready_o)) |-> $stable(digest_o)); // R11
endmodule

bind sha256_iter_core sha256_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .blk_valid_i (blk_valid_i),
    .ready_o     (ready_o),
    .done_o      (done_o),
    .digest_o    (digest_o)
);

// File: tb/tb_sha256_iter_core.sv
module tb_sha256_iter_core;

    localparam int WATCHDOG = 200000;
    localparam int NVEC     = 3;

    localparam logic [255:0] DIG_IV  = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
    localparam logic [255:0] DIG_ABC = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    localparam logic [511:0] BLK_ABC = {32'h61626380, 448'h0, 32'h00000018};
    localparam logic [511:0] BLK_NUL = {32'h80000000, 480'h0};

    localparam logic [511:0] VEC_B0 [NVEC] = '{
        BLK_NUL,
        BLK_ABC,
        {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
         32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
         32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
         32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000}
    };
    localparam logic [511:0] VEC_B1 [NVEC] = '{
        512'h0,
        512'h0,
        {480'h0, 32'h000001c0}
    };
    localparam int VEC_NB [NVEC] = '{1, 1, 2};
    localparam logic [255:0] VEC_DIG [NVEC] = '{
        256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855,
        DIG_ABC,
        256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         blk_valid_i = 1'b0;
    logic         blk_last_i = 1'b0;
    logic [511:0] blk_data_i = '0;
    logic         ready_o;
    logic         done_o;
    logic [255:0] digest_o;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    sha256_iter_core dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .blk_valid_i (blk_valid_i),
        .blk_last_i  (blk_last_i),
        .blk_data_i  (blk_data_i),
        .ready_o     (ready_o),
        .done_o      (done_o),
        .digest_o    (digest_o)
    );

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n       = 1'b0;
        start_i     = 1'b0;
        blk_valid_i = 1'b0;
        blk_last_i  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 digest after start", digest_o, DIG_IV);
    endtask

    // present one block and follow it to completion
    task automatic run_block(input logic [511:0] data, input logic last,
                             input logic with_start, input bit noise);
        logic [255:0] ref_dig;
        int busy;
        bit early_done;
        start_i     = with_start;
        blk_valid_i = 1'b1;
        blk_last_i  = last;
        blk_data_i  = data;
        @(negedge clk);
        start_i     = 1'b0;
        blk_valid_i = 1'b0;
        chk("R3 ready drops after accept", {255'h0, ready_o}, 256'h0);
        ref_dig    = digest_o;
        busy       = 1;
        early_done = 0;
        while (!ready_o && busy < 200) begin
            if (noise && busy == 10) begin
                start_i     = 1'b1;
                blk_valid_i = 1'b1;
                blk_data_i  = BLK_NUL;
            end
            if (noise && busy == 13) begin
                start_i     = 1'b0;
                blk_valid_i = 1'b0;
            end
            @(negedge clk);
            if (!ready_o) begin
                busy++;
                if (digest_o !== ref_dig) begin
                    n_err++;
                    $display("FAIL R11 digest moved while busy: actual %h expected %h", digest_o, ref_dig);
                end
                if (done_o) early_done = 1;
            end
        end
        n_chk++;
        chk("R4 busy cycle count", 256'(busy), 256'd65);
        chk("R7 no done while busy", {255'h0, early_done}, 256'h0);
        chk("R6/R7 done matches last flag", {255'h0, done_o}, {255'h0, last});
        if (last) begin
            @(negedge clk);
            chk("R7 done lasts one cycle", {255'h0, done_o}, 256'h0);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1 during and after reset
        @(negedge clk);
        chk("R1 ready in reset", {255'h0, ready_o}, 256'h1);
        chk("R1 digest in reset", digest_o, DIG_IV);
        do_reset();
        chk("R1 ready after reset", {255'h0, ready_o}, 256'h1);
        chk("R1 done after reset", {255'h0, done_o}, 256'h0);
        chk("R1 digest after reset", digest_o, DIG_IV);

        // vector table: R5 single blocks, R6 chaining, R3 word order
        for (int v = 0; v < NVEC; v++) begin
            pulse_start();
            run_block(VEC_B0[v], VEC_NB[v] == 1, 1'b0, 1'b0);
            if (VEC_NB[v] == 2) begin
                run_block(VEC_B1[v], 1'b1, 1'b0, 1'b0);
            end
            chk($sformatf("R5 digest of vector %0d", v), digest_o, VEC_DIG[v]);
        end

        // R8 / R9: start and valid held high mid-block are ignored
        pulse_start();
        run_block(BLK_ABC, 1'b1, 1'b0, 1'b1);
        chk("R8 R9 digest unaffected by busy inputs", digest_o, DIG_ABC);
        @(negedge clk);
        chk("R9 no block accepted from busy valid", {255'h0, ready_o}, 256'h1);

        // R10: start together with valid restarts from IV (digest now non-IV)
        run_block(BLK_ABC, 1'b1, 1'b1, 1'b0);
        chk("R10 start+valid hashes from IV", digest_o, DIG_ABC);

        // R6: without start, a second block chains on the previous value
        run_block(BLK_ABC, 1'b1, 1'b0, 1'b0);
        n_chk++;
        if (digest_o === DIG_ABC) begin
            n_err++;
            $display("FAIL R6 chained digest: actual %h expected value different from %h", digest_o, DIG_ABC);
        end

        // R1: reset in the middle of a block
        blk_valid_i = 1'b1;
        blk_last_i  = 1'b1;
        blk_data_i  = BLK_ABC;
        @(negedge clk);
        blk_valid_i = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 ready on mid-block reset", {255'h0, ready_o}, 256'h1);
        chk("R1 digest on mid-block reset", digest_o, DIG_IV);
        rst_n = 1'b1;
        @(negedge clk);
        run_block(BLK_ABC, 1'b1, 1'b0, 1'b0);
        chk("R5 digest after mid-block reset", digest_o, DIG_ABC);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule